// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a 32768 Hz enable stream into a one-second tick and applies a digital rate trim. The crystal is not touched. Instead, within a repeating cycle of minutes, the first second of each of the first 2N minutes is made shorter or longer at the divide-by-128 stage. The 5-bit magnitude N sets how many minutes are affected, and a direction bit chooses between a faster clock and a slower clock.

A stop input freezes the divider and clears the part of the second already counted. A frequency-test input exposes a 512 Hz square wave, which comes from the low divider stage and so ignores the calibration. The tick is a single system-clock pulse that can drive a time-of-day counter.

Top module: `cal_prescaler`

## Requirements
- R1: With no alteration in force, a tick follows every STAGES*128 accepted enables. The default is 256*128 = 32768.
- R2: The only second ever altered is second 0 of minutes 0 to 2N-1 of each MINS-minute cycle. N is the sampled magnitude, and N large enough covers every minute.
- R3: With the direction bit at 1, an altered second is 256 enables shorter than nominal.
- R4: With the direction bit at 0, an altered second is 128 enables longer than nominal.
- R5: While stop is 1, no tick occurs and the partial second is cleared. Once stop returns to 0, an unaltered second ends after exactly STAGES*128 enables.
- R6: The tick is high for one clock only. It appears in the cycle after the edge that accepts the last enable of a second.
- R7: With ftest at 1, test_out equals bit 5 of the enable count within the current 128-enable group. This gives a 512 Hz square wave that no calibration setting changes. With ftest at 0, test_out is 0.
- R8: The magnitude and direction are sampled only when the divider sits at the start of a minute. A change made during a minute takes effect from the next minute.
- R9: Only cycles with osc_en at 1 advance the divider. Cycles with osc_en at 0 stretch time but do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse for each oscillator period |
| cal_mag | input | 5 | Calibration magnitude N |
| cal_pos | input | 1 | 1 for faster, 0 for slower |
| stop | input | 1 | Halts and clears the divider |
| ftest | input | 1 | Enables the 512 Hz test output |
| sec_tick | output | 1 | One-clock pulse per second |
| test_out | output | 1 | 512 Hz test square wave, gated by ftest |

## Verification
The assertions assume that osc_en is a clean one-cycle qualifier and that stop is held for whole clock cycles. The pulse-width property also needs every second to last more than one enable, which holds for any STAGES of 3 or more. The bench reduces STAGES, the seconds per minute and the minutes per cycle so that three full calibration cycles fit in a short run. It changes calibration only during the last second of a cycle, so each new setting is sampled at a known minute start. Inputs change one time unit after a falling edge, and the bench samples on falling edges, so every input it applies stays inside these assumptions.

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int LO_W   = 7,
  parameter int STAGES = 256,
  parameter int SECS   = 60,
  parameter int MINS   = 64,
  parameter int MAG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  input  logic             stop,
  input  logic             ftest,
  output logic             sec_tick,
  output logic             test_out
);
  localparam int HI_W  = $clog2(STAGES + 2);
  localparam int SEC_W = (SECS > 1) ? $clog2(SECS) : 1;
  localparam int MIN_W = (MINS > 1) ? $clog2(MINS) : 1;
  localparam int CMP_W = ((MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1) + 1;

  logic [LO_W-1:0]  lo;
  logic [HI_W-1:0]  hi, last;
  logic [SEC_W-1:0] sec_c;
  logic [MIN_W-1:0] min_c;
  logic [MAG_W-1:0] mag_q;
  logic             pos_q, alter, sec_end, at_min_start;

  assign at_min_start = (lo == '0) && (hi == '0) && (sec_c == '0);
  assign alter = (sec_c == '0) && (CMP_W'(min_c) < CMP_W'({mag_q, 1'b0}));
  assign last = alter ? (pos_q ? HI_W'(STAGES - 3) : HI_W'(STAGES))
                      : HI_W'(STAGES - 1);
  assign sec_end = osc_en && !stop && (&lo) && (hi == last);
  assign test_out = ftest & lo[LO_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
      sec_c <= '0;
      min_c <= '0;
      mag_q <= '0;
      pos_q <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      if (at_min_start) begin
        mag_q <= cal_mag;
        pos_q <= cal_pos;
      end
      if (stop) begin
        lo <= '0;
        hi <= '0;
      end else if (osc_en) begin
        lo <= lo + 1'b1;
        if (&lo) hi <= (hi == last) ? '0 : hi + 1'b1;
      end
      if (sec_end) begin
        if (sec_c == SEC_W'(SECS - 1)) begin
          sec_c <= '0;
          min_c <= (min_c == MIN_W'(MINS - 1)) ? '0 : min_c + 1'b1;
        end else begin
          sec_c <= sec_c + 1'b1;
        end
      end
    end
  end

  assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  assert_tick_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_en));
  assert_stop_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);
  assert_stop_clears_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !test_out);
  assert_cal_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_c != '0) |=> ($stable(mag_q) && $stable(pos_q)));
endmodule

// File: tb/sim_cal_prescaler.sv
module sim_cal_prescaler;
  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b1, cal_pos = 1'b1;
  logic stop = 1'b0, ftest = 1'b1;
  logic [4:0] cal_mag = 5'd1;
  logic sec_tick, test_out;
  int checks = 0, errors = 0, cnt = 0;
  int q[$];
  string phase = "R1";
  bit done = 0;

  localparam int STG = 8, SPM = 4, MPC = 8;
  localparam int NOM = STG * 128;

  cal_prescaler #(.STAGES(STG), .SECS(SPM), .MINS(MPC)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_mag(cal_mag),
    .cal_pos(cal_pos), .stop(stop), .ftest(ftest),
    .sec_tick(sec_tick), .test_out(test_out));

  always #5 clk = ~clk;

  function automatic string len_tag(int len);
    if (len == NOM - 256) return "R2 R3";
    if (len == NOM + 128) return "R2 R4";
    return "R1";
  endfunction

  task automatic push_cycle(int mag, bit pos, int mins);
    for (int m = 0; m < mins; m++)
      for (int s = 0; s < SPM; s++)
        q.push_back((s == 0 && m < 2 * mag) ? (pos ? NOM - 256 : NOM + 128) : NOM);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0;
      checks++;
      if (sec_tick !== 1'b0 || test_out !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: tick=%b test=%b expected 0 0", sec_tick, test_out);
      end
    end else begin
      if (stop) cnt = 0;
      else if (osc_en) cnt++;
      checks++;
      if (test_out !== (ftest && cnt[5])) begin
        errors++;
        $display("FAIL R7 test_out=%b expected %b", test_out, ftest && cnt[5]);
      end
      if (sec_tick) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected tick: actual 1 expected 0");
        end else begin
          int e;
          e = q.pop_front();
          if (cnt != e) begin
            errors++;
            $display("FAIL %s %s second length %0d expected %0d", phase, len_tag(e), cnt, e);
          end
        end
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    push_cycle(1, 1'b1, MPC);
    while (q.size() > 1) @(negedge clk);
    #1 cal_mag = 5'd2; cal_pos = 1'b0; phase = "R8";
    push_cycle(2, 1'b0, MPC);
    while (q.size() > 1) @(negedge clk);
    #1 cal_mag = 5'd31; cal_pos = 1'b1;
    push_cycle(31, 1'b1, MPC);
    while (q.size() > 1) @(negedge clk);
    #1 cal_mag = 5'd0; ftest = 1'b0;
    push_cycle(0, 1'b0, 1);
    while (q.size() > 0) @(negedge clk);
    repeat (300) @(negedge clk);
    #1 stop = 1'b1; ftest = 1'b1; phase = "R5 R9";
    repeat (500) @(negedge clk);
    #1 stop = 1'b0;
    q.push_back(NOM);
    while (q.size() > 0) begin
      @(negedge clk);
      #1 osc_en = ~osc_en;
    end
    osc_en = 1'b1;
    repeat (20) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished, %0d seconds pending expected 0", q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule